// File: doc/BRIEF.md
# Shared Interrupt Distributor for Two Processor Interfaces

The block gathers up to 32 peripheral interrupt lines. For each of two processor-side interfaces it picks the most urgent interrupt that is pending, enabled and routed there, and presents that interrupt's number and priority. Software configures the block through a word-wide register port: a master enable, enable and pending bit banks (write one to set, write one to clear), one byte per source for priority, one byte per source for the target processors, and one bit per source that selects edge or level sensing.

Each source keeps a pending bit and an active bit. A processor takes an interrupt with a one-cycle acknowledge pulse, which claims whatever that interface is presenting. It ends the interrupt with a deactivate pulse that carries the interrupt number. Delivery is one-of-many: when any target acknowledges, the interrupt leaves the pending state for every target. Input line k carries interrupt number 32+k.

Register word addresses: 0 master enable (bit 0); 1 set-enable; 2 clear-enable; 3 set-pending; 4 clear-pending; 5 active status (read only); 6 trigger select; 8–15 priorities; 16–23 targets. Every other word reads as zero.

Top module: `irq_distributor`

## Requirements
- R1: While bit 0 of word 0 is clear, no interface shows a valid interrupt, whatever the state of each source. Setting the bit restores forwarding without losing any pending state.
- R2: Writing ones to word 1 sets source enables, and writing ones to word 2 clears them. Bit k stands for source k (number 32+k, so the bit is the number mod 32), and both words read back the enable bits. A disabled source is never forwarded, but it stays pending, and it does not affect the other sources.
- R3: The priority of source k is in word 8+k/4, bits [8*(k%4)+7 : 8*(k%4)]. Only the upper 5 bits are stored, so the low 3 bits read as zero and writes to them are ignored.
- R4: The target byte of source k is in word 16+k/4, at the same byte position as its priority. Bit c of that byte routes the source to interface c, and byte bits at or above the number of interfaces read as zero.
- R5: Each interface shows the candidate with the numerically smallest priority, and on a tie the smaller number wins. The output gives the number 32+k and the stored priority, with its low bits zero.
- R6: A source whose bit in word 6 is 1 (edge) becomes pending on a rising edge of its synchronized input. It stays pending after the input falls. Further edges while it is pending change nothing, and after an acknowledge an input held high does not make it pending again.
- R7: A source whose bit in word 6 is 0 (level) reads as pending while its synchronized input is high, and stops being pending once the input goes low, unless software set it pending.
- R8: An acknowledge pulse on an interface that is showing a valid interrupt clears that source's pending state for every interface and sets its active bit (word 5). An active source is never forwarded.
- R9: A level source acknowledged while its input is still high becomes pending and active at once. It is forwarded again after it is deactivated.
- R10: A deactivate pulse with number 32+k clears the active bit of source k and leaves pending state untouched. A deactivate for a source that is not active changes nothing.
- R11: Writing ones to word 3 makes sources pending, and writing ones to word 4 clears their latched pending state. Both words read back the pending state.
- R12: After reset all enables, pending bits, active bits, priorities, targets and trigger bits are zero, and no interface shows a valid interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | NUM_SRC | Peripheral interrupt lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| ack_i | input | NUM_CPU | Per-interface acknowledge pulse |
| dea_i | input | NUM_CPU | Per-interface deactivate pulse |
| dea_id_i | input | NUM_CPU*10 | Interrupt number to deactivate, one field per interface |
| fwd_valid_o | output | NUM_CPU | Interface c has an interrupt to take |
| fwd_id_o | output | NUM_CPU*10 | Presented interrupt number per interface |
| fwd_prio_o | output | NUM_CPU*8 | Presented priority per interface |

## Verification
Every cycle the assertions check the following. The master enable blocks every interface. Any presented interrupt is enabled, not active, and in the valid number range, and its priority has zero low bits. An acknowledge makes the source active on the next edge, and no interface shows that interrupt afterwards. A deactivate clears the active bit. Other behaviours depend on sequences, so only the directed scenarios can show them: which of several candidates wins on priority and number, the edge-versus-level difference when an input stays high through an acknowledge, software pending, and the return of a level source after deactivation.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int SPI_BASE = 32;
  localparam int WORD_W   = 32;

  // register word addresses
  localparam int A_CTRL  = 0;
  localparam int A_SETEN = 1;
  localparam int A_CLREN = 2;
  localparam int A_SETPD = 3;
  localparam int A_CLRPD = 4;
  localparam int A_ACT   = 5;
  localparam int A_TRIG  = 6;
  localparam int A_PRIO  = 8;
  localparam int A_TGT   = 16;

  // interrupt number carried by input line k
  function automatic logic [ID_W-1:0] src_to_id(input int k);
    return ID_W'(SPI_BASE + k);
  endfunction

  // stored upper priority bits placed back in an 8-bit field
  function automatic logic [PRIO_W-1:0] prio_expand(input logic [PRIO_W-1:0] raw,
                                                     input int impl);
    return raw << (PRIO_W - impl);
  endfunction

  // byte lane of source k inside its packed word
  function automatic int lane_lsb(input int k);
    return 8 * (k % 4);
  endfunction
endpackage

// File: rtl/irqd_sync.sv
`timescale 1ns/1ps
module irqd_sync #(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] rise_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_line
    logic [SYNC_STAGES-1:0] ff;
    logic                   prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ff   <= '0;
        prev <= 1'b0;
      end else begin
        ff   <= {ff[SYNC_STAGES-2:0], src_i[k]};
        prev <= ff[SYNC_STAGES-1];
      end
    end
    assign lvl_o[k]  = ff[SYNC_STAGES-1];
    assign rise_o[k] = ff[SYNC_STAGES-1] & ~prev;
  end
endmodule

// File: rtl/irqd_regs.sv
`timescale 1ns/1ps
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPU   = 2,
  parameter int PRIO_IMPL = 5,
  parameter int ADDR_W    = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [WORD_W-1:0]                   wdata_i,
  output logic [WORD_W-1:0]                   rdata_o,
  input  logic [NUM_SRC-1:0]                  pend_i,
  input  logic [NUM_SRC-1:0]                  act_i,
  output logic                                gen_en_o,
  output logic [NUM_SRC-1:0]                  en_o,
  output logic [NUM_SRC-1:0]                  edge_o,
  output logic [NUM_SRC-1:0][PRIO_IMPL-1:0]   prio_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]     tgt_o,
  output logic [NUM_SRC-1:0]                  set_pend_o,
  output logic [NUM_SRC-1:0]                  clr_pend_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int word);
    return a == ADDR_W'(word);
  endfunction

  logic [NUM_SRC-1:0] wbits;
  assign wbits = wdata_i[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_o <= 1'b0;
      en_o     <= '0;
      edge_o   <= '0;
    end else if (wr_i) begin
      if (hit(addr_i, A_CTRL))  gen_en_o <= wdata_i[0];
      if (hit(addr_i, A_SETEN)) en_o     <= en_o | wbits;
      if (hit(addr_i, A_CLREN)) en_o     <= en_o & ~wbits;
      if (hit(addr_i, A_TRIG))  edge_o   <= wbits;
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_field
    localparam int LSB = lane_lsb(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_o[k] <= '0;
        tgt_o[k]  <= '0;
      end else if (wr_i) begin
        if (hit(addr_i, A_PRIO + k / 4))
          prio_o[k] <= wdata_i[LSB + PRIO_W - PRIO_IMPL +: PRIO_IMPL];
        if (hit(addr_i, A_TGT + k / 4))
          tgt_o[k] <= wdata_i[LSB +: NUM_CPU];
      end
    end
  end

  assign set_pend_o = (wr_i && hit(addr_i, A_SETPD)) ? wbits : '0;
  assign clr_pend_o = (wr_i && hit(addr_i, A_CLRPD)) ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, A_CTRL))                               rdata_o[0] = gen_en_o;
    if (hit(addr_i, A_SETEN) || hit(addr_i, A_CLREN))      rdata_o = WORD_W'(en_o);
    if (hit(addr_i, A_SETPD) || hit(addr_i, A_CLRPD))      rdata_o = WORD_W'(pend_i);
    if (hit(addr_i, A_ACT))                                rdata_o = WORD_W'(act_i);
    if (hit(addr_i, A_TRIG))                               rdata_o = WORD_W'(edge_o);
    for (int k = 0; k < NUM_SRC; k++) begin
      if (hit(addr_i, A_PRIO + k / 4))
        rdata_o[lane_lsb(k) +: PRIO_W] = prio_expand(PRIO_W'(prio_o[k]), PRIO_IMPL);
      if (hit(addr_i, A_TGT + k / 4))
        rdata_o[lane_lsb(k) +: NUM_CPU] = tgt_o[k];
    end
  end
endmodule

// File: rtl/irqd_state.sv
`timescale 1ns/1ps
module irqd_state
  import irqd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 2,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            lvl_i,
  input  logic [NUM_SRC-1:0]            rise_i,
  input  logic [NUM_SRC-1:0]            edge_i,
  input  logic [NUM_SRC-1:0]            set_pend_i,
  input  logic [NUM_SRC-1:0]            clr_pend_i,
  input  logic [NUM_CPU-1:0]            ack_i,
  input  logic [NUM_CPU-1:0]            fwd_valid_i,
  input  logic [NUM_CPU-1:0][IDX_W-1:0] fwd_idx_i,
  input  logic [NUM_CPU-1:0]            dea_i,
  input  logic [NUM_CPU-1:0][ID_W-1:0]  dea_id_i,
  output logic [NUM_SRC-1:0]            pend_o,
  output logic [NUM_SRC-1:0]            act_o,
  output logic [NUM_SRC-1:0]            ack_hit_o,
  output logic [NUM_SRC-1:0]            dea_hit_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    always_comb begin
      ack_hit_o[k] = 1'b0;
      dea_hit_o[k] = 1'b0;
      for (int c = 0; c < NUM_CPU; c++) begin
        if (ack_i[c] && fwd_valid_i[c] && fwd_idx_i[c] == IDX_W'(k)) ack_hit_o[k] = 1'b1;
        if (dea_i[c] && dea_id_i[c] == src_to_id(k))                 dea_hit_o[k] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
        act_o[k]  <= 1'b0;
      end else begin
        // a fresh edge in the acknowledge cycle keeps the source pending
        pend_q[k] <= (pend_q[k] & ~clr_pend_i[k] & ~ack_hit_o[k])
                   | set_pend_i[k] | (edge_i[k] & rise_i[k]);
        act_o[k]  <= (act_o[k] & ~dea_hit_o[k]) | ack_hit_o[k];
      end
    end

    assign pend_o[k] = pend_q[k] | (~edge_i[k] & lvl_i[k]);
  end
endmodule

// File: rtl/irqd_pick.sv
`timescale 1ns/1ps
module irqd_pick #(
  parameter int NUM_SRC   = 32,
  parameter int PRIO_IMPL = 5,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]                cand_i,
  input  logic [NUM_SRC-1:0][PRIO_IMPL-1:0] prio_i,
  output logic                              valid_o,
  output logic [IDX_W-1:0]                  idx_o,
  output logic [PRIO_IMPL-1:0]              prio_o
);
  // ascending scan with strict compare: equal priority keeps the lower index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cand_i[k] && (!valid_o || prio_i[k] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(k);
        prio_o  = prio_i[k];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_CPU     = 2,
  parameter int PRIO_IMPL   = 5,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_src_i,
  input  logic                      reg_wr_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [WORD_W-1:0]         reg_wdata_i,
  output logic [WORD_W-1:0]         reg_rdata_o,
  input  logic [NUM_CPU-1:0]        ack_i,
  input  logic [NUM_CPU-1:0]        dea_i,
  input  logic [NUM_CPU*ID_W-1:0]   dea_id_i,
  output logic [NUM_CPU-1:0]        fwd_valid_o,
  output logic [NUM_CPU*ID_W-1:0]   fwd_id_o,
  output logic [NUM_CPU*PRIO_W-1:0] fwd_prio_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic                               gen_en;
  logic [NUM_SRC-1:0]                 en_vec, edge_vec, pend_vec, act_vec;
  logic [NUM_SRC-1:0]                 lvl_vec, rise_vec, set_pend, clr_pend;
  logic [NUM_SRC-1:0]                 ack_hit, dea_hit;
  logic [NUM_SRC-1:0][PRIO_IMPL-1:0]  prio_arr;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]    tgt_arr;
  logic [NUM_CPU-1:0][IDX_W-1:0]      win_idx;
  logic [NUM_CPU-1:0][PRIO_IMPL-1:0]  win_prio;
  logic [NUM_CPU-1:0][ID_W-1:0]       dea_id;

  irqd_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_i(irq_src_i), .lvl_o(lvl_vec), .rise_o(rise_vec)
  );

  irqd_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_IMPL(PRIO_IMPL),
              .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .pend_i(pend_vec), .act_i(act_vec),
    .gen_en_o(gen_en), .en_o(en_vec), .edge_o(edge_vec), .prio_o(prio_arr),
    .tgt_o(tgt_arr), .set_pend_o(set_pend), .clr_pend_o(clr_pend)
  );

  irqd_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_vec), .rise_i(rise_vec), .edge_i(edge_vec),
    .set_pend_i(set_pend), .clr_pend_i(clr_pend), .ack_i(ack_i),
    .fwd_valid_i(fwd_valid_o), .fwd_idx_i(win_idx), .dea_i(dea_i), .dea_id_i(dea_id),
    .pend_o(pend_vec), .act_o(act_vec), .ack_hit_o(ack_hit), .dea_hit_o(dea_hit)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cand
      assign cand[k] = gen_en & en_vec[k] & pend_vec[k] & ~act_vec[k] & tgt_arr[k][c];
    end

    irqd_pick #(.NUM_SRC(NUM_SRC), .PRIO_IMPL(PRIO_IMPL)) u_pick (
      .cand_i(cand), .prio_i(prio_arr), .valid_o(fwd_valid_o[c]),
      .idx_o(win_idx[c]), .prio_o(win_prio[c])
    );

    assign dea_id[c]                   = dea_id_i[c*ID_W +: ID_W];
    assign fwd_id_o[c*ID_W +: ID_W]    = src_to_id(int'(win_idx[c]));
    assign fwd_prio_o[c*PRIO_W +: PRIO_W] = prio_expand(PRIO_W'(win_prio[c]), PRIO_IMPL);
  end
endmodule

// File: rtl/irqd_chk.sv
`timescale 1ns/1ps
module irqd_chk
  import irqd_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPU   = 2,
  parameter int PRIO_IMPL = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      gen_en,
  input logic [NUM_SRC-1:0]        en_vec,
  input logic [NUM_SRC-1:0]        act_vec,
  input logic [NUM_SRC-1:0]        ack_hit,
  input logic [NUM_SRC-1:0]        dea_hit,
  input logic [NUM_CPU-1:0]        ack_i,
  input logic [NUM_CPU-1:0]        fwd_valid,
  input logic [NUM_CPU*ID_W-1:0]   fwd_id,
  input logic [NUM_CPU*PRIO_W-1:0] fwd_prio
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [PRIO_W-1:0] LOW_MASK = PRIO_W'((1 << (PRIO_W - PRIO_IMPL)) - 1);

  // R1
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> fwd_valid == '0);

  // R8
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit != '0) |=> ((act_vec & $past(ack_hit)) == $past(ack_hit)));

  // R10
  dea_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dea_hit & ~ack_hit) != '0) |=> ((act_vec & $past(dea_hit & ~ack_hit)) == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [ID_W-1:0]   id_c;
    logic [PRIO_W-1:0] pr_c;
    logic [IDX_W-1:0]  sidx;
    assign id_c = fwd_id[c*ID_W +: ID_W];
    assign pr_c = fwd_prio[c*PRIO_W +: PRIO_W];
    assign sidx = IDX_W'(id_c - ID_W'(SPI_BASE));

    // R2
    only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> en_vec[sidx]);

    // R3
    prio_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> (pr_c & LOW_MASK) == '0);

    // R5
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> (id_c >= ID_W'(SPI_BASE) && id_c < ID_W'(SPI_BASE + NUM_SRC)));

    // R8
    active_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> !act_vec[sidx]);

    // R8
    no_repeat_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[c] && fwd_valid[c]) |=> !(fwd_valid[c] && id_c == $past(id_c)));
  end
endmodule

bind irq_distributor irqd_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_IMPL(PRIO_IMPL))
  u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .en_vec(en_vec), .act_vec(act_vec),
    .ack_hit(ack_hit), .dea_hit(dea_hit), .ack_i(ack_i), .fwd_valid(fwd_valid_o),
    .fwd_id(fwd_id_o), .fwd_prio(fwd_prio_o)
  );

// File: tb/tb_irq_distributor.sv
`timescale 1ns/1ps
module tb_irq_distributor;
  localparam int NS = 32, NC = 2, IW = 10, PW = 8, AW = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     src = '0;
  logic              wr = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NC-1:0]     ack = '0, dea = '0;
  logic [NC*IW-1:0]  dea_id = '0;
  logic [NC-1:0]     fv;
  logic [NC*IW-1:0]  fid;
  logic [NC*PW-1:0]  fpr;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  irq_distributor dut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .dea_i(dea),
    .dea_id_i(dea_id), .fwd_valid_o(fv), .fwd_id_o(fid), .fwd_prio_o(fpr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    addr = AW'(a); #1;
    check(tag, rdata, exp);
  endtask

  task automatic fwd_chk(input int c, input logic v, input int id, input int pr,
                         input string tag);
    check({tag, " valid"}, 32'(fv[c]), 32'(v));
    if (v) begin
      check({tag, " id"}, 32'(fid[c*IW +: IW]), 32'(id));
      check({tag, " prio"}, 32'(fpr[c*PW +: PW]), 32'(pr));
    end
  endtask

  task automatic do_ack(input int c);
    @(negedge clk); ack[c] = 1'b1;
    @(negedge clk); ack[c] = 1'b0;
  endtask

  task automatic do_dea(input int c, input int id);
    @(negedge clk); dea[c] = 1'b1; dea_id[c*IW +: IW] = IW'(id);
    @(negedge clk); dea[c] = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(0, 32'h0, "R12 ctrl");
    rd_chk(1, 32'h0, "R12 enable");
    rd_chk(3, 32'h0, "R12 pending");
    rd_chk(8, 32'h0, "R12 prio");
    rd_chk(16, 32'h0, "R12 target");
    fwd_chk(0, 1'b0, 0, 0, "R12 cpu0");
    fwd_chk(1, 1'b0, 0, 0, "R12 cpu1");
  endtask

  task automatic t_fields;
    wr_reg(8, 32'hFFFF_FFFF);
    rd_chk(8, 32'hF8F8_F8F8, "R3 low bits");
    wr_reg(16, 32'hFFFF_FFFF);
    rd_chk(16, 32'h0303_0303, "R4 target width");
    wr_reg(8, 32'h4000_0000);   // src3 0x40
    wr_reg(9, 32'h0000_2000);   // src5 0x20, src7 0x00
    wr_reg(10, 32'h0000_2000);  // src9 0x20
    wr_reg(11, 32'h0000_0060);  // src12 0x60
    wr_reg(13, 32'h0000_0010);  // src20 0x10
    rd_chk(9, 32'h0000_2000, "R3 readback");
    wr_reg(16, 32'h0100_0000);
    wr_reg(17, 32'h0100_0100);
    wr_reg(18, 32'h0000_0100);
    wr_reg(19, 32'h0000_0002);
    wr_reg(21, 32'h0000_0002);
    wr_reg(6, (1 << 3) | (1 << 5) | (1 << 7) | (1 << 9) | (1 << 12));
    wr_reg(1, (1 << 3) | (1 << 5) | (1 << 7) | (1 << 9) | (1 << 12) | (1 << 20));
    rd_chk(2, (1 << 3) | (1 << 5) | (1 << 7) | (1 << 9) | (1 << 12) | (1 << 20),
           "R2 enable readback");
    wr_reg(0, 32'h1);
  endtask

  task automatic t_select;
    @(negedge clk); src[3] = 1'b1; src[5] = 1'b1; src[9] = 1'b1;
    tick(2);
    src[3] = 1'b0; src[5] = 1'b0; src[9] = 1'b0;
    tick(5);
    rd_chk(3, (1 << 3) | (1 << 5) | (1 << 9), "R6 edges latched");
    fwd_chk(0, 1'b1, 37, 8'h20, "R5 tie lowest id");
    fwd_chk(1, 1'b0, 0, 0, "R4 cpu1 not targeted");
  endtask

  task automatic t_master;
    wr_reg(0, 32'h0);
    fwd_chk(0, 1'b0, 0, 0, "R1 master off");
    rd_chk(3, (1 << 3) | (1 << 5) | (1 << 9), "R1 pending kept");
    wr_reg(0, 32'h1);
    fwd_chk(0, 1'b1, 37, 8'h20, "R1 master on");
  endtask

  task automatic t_enable;
    wr_reg(2, 1 << 5);
    fwd_chk(0, 1'b1, 41, 8'h20, "R2 disabled source skipped");
    rd_chk(3, (1 << 3) | (1 << 5) | (1 << 9), "R2 still pending");
    wr_reg(1, 1 << 5);
    fwd_chk(0, 1'b1, 37, 8'h20, "R2 re-enabled");
  endtask

  task automatic t_one_of_n;
    wr_reg(17, 32'h0100_0300);
    fwd_chk(1, 1'b1, 37, 8'h20, "R4 cpu1 targeted");
    do_ack(1);
    fwd_chk(0, 1'b1, 41, 8'h20, "R8 cpu0 moves on");
    fwd_chk(1, 1'b0, 0, 0, "R8 cpu1 idle");
    rd_chk(3, (1 << 3) | (1 << 9), "R8 pending cleared");
    rd_chk(5, 1 << 5, "R8 active set");
  endtask

  task automatic t_deact;
    do_dea(0, 40);
    rd_chk(5, 1 << 5, "R10 inactive deactivate ignored");
    do_dea(0, 37);
    rd_chk(5, 32'h0, "R10 active cleared");
    rd_chk(3, (1 << 3) | (1 << 9), "R10 pending untouched");
    fwd_chk(0, 1'b1, 41, 8'h20, "R10 no re-forward");
  endtask

  task automatic t_sw_pend;
    wr_reg(4, (1 << 3) | (1 << 9));
    rd_chk(3, 32'h0, "R11 clear pending");
    fwd_chk(0, 1'b0, 0, 0, "R11 nothing left");
    wr_reg(3, 1 << 7);
    fwd_chk(0, 1'b1, 39, 8'h00, "R11 set pending");
    do_ack(0);
    fwd_chk(0, 1'b0, 0, 0, "R11 acked");
    do_dea(0, 39);
    rd_chk(5, 32'h0, "R11 clean");
  endtask

  task automatic t_edge;
    @(negedge clk); src[12] = 1'b1;
    tick(5);
    fwd_chk(1, 1'b1, 44, 8'h60, "R6 edge forward");
    src[12] = 1'b0;
    tick(3);
    rd_chk(3, 1 << 12, "R6 held after fall");
    src[12] = 1'b1;
    tick(5);
    do_ack(1);
    tick(2);
    rd_chk(3, 32'h0, "R6 repeat edge merged, high input ignored");
    rd_chk(5, 1 << 12, "R6 active");
    src[12] = 1'b0;
    do_dea(1, 44);
    fwd_chk(1, 1'b0, 0, 0, "R6 done");
  endtask

  task automatic t_level;
    @(negedge clk); src[20] = 1'b1;
    tick(4);
    fwd_chk(1, 1'b1, 52, 8'h10, "R7 level forward");
    src[20] = 1'b0;
    tick(4);
    fwd_chk(1, 1'b0, 0, 0, "R7 level drop");
    rd_chk(3, 32'h0, "R7 not pending");
    src[20] = 1'b1;
    tick(4);
    do_ack(1);
    tick(1);
    rd_chk(3, 1 << 20, "R9 pending again");
    rd_chk(5, 1 << 20, "R9 and active");
    fwd_chk(1, 1'b0, 0, 0, "R9 hidden while active");
    do_dea(1, 52);
    fwd_chk(1, 1'b1, 52, 8'h10, "R9 back after deactivate");
    src[20] = 1'b0;
    tick(4);
    fwd_chk(1, 1'b0, 0, 0, "R7 final");
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_fields;
    t_select;
    t_master;
    t_enable;
    t_one_of_n;
    t_deact;
    t_sw_pend;
    t_edge;
    t_level;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule